// File: doc/BRIEF.md
# Aliased Control Register Read Decoder

This block is the read side of the control register file of a memory-mapped address translation unit. It takes one request per cycle into a 128 KiB register window. Each request carries an address, a byte count and a write flag. One cycle later it gives back a response code and up to 64 bits of little-endian data. The window holds two identical 64 KiB pages, because address bit 16 plays no part in the decode. Reads return the identification words, the control, status, interrupt and error words, and the pointers of the command queue and the event queue.

Only reads of 4 or 8 bytes are legal. An 8-byte read returns a full value for the four 64-bit registers only: error interrupt config 0, translation table base, command queue base and event queue base. Any other legal read of an unmapped location, and any other 8-byte read, returns zero with an OK code. Writes are refused with an error code, so every register keeps its reset value. At reset both queue indices are zero, and the low five bits of each queue base hold that queue's log2 depth.

Top module: `ctlreg_rd_dec`

## Requirements
- R1: `rsp_vld` is high in exactly the cycle after each cycle with `req_vld` high, and low otherwise.
- R2: `rsp_code` is 0 for OK and 2 for error. Every write gets code 2 with zero data and changes no register.
- R3: A read whose `req_size` is neither 4 nor 8 gets code 2 with zero data.
- R4: Address bit 16 is ignored, so any offset in the upper page reads the same as the matching offset in the lower page.
- R5: An 8-byte read at 0x068 (error interrupt config 0), 0x080 (table base), 0x090 (command queue base) or 0x0A0 (event queue base) returns the full 64-bit value. Any other 8-byte read returns zero with code 0.
- R6: A 4-byte read returns its word in data bits 31:0, with bits 63:32 zero. For a 64-bit register, bits 31:0 come from its base offset and bits 63:32 from base offset plus 4.
- R7: The identification words sit at 0x000 to 0x014, 4 bytes apart. ID0 = 0x369: bit 0 stage-1 support, bits 3:2 table format 2, bits 5:4 endianness 2 (little), bits 7:6 stall model 1, bit 8 terminate model 1, bits 10:9 stream table levels 1. ID1 holds the stream ID width in bits 5:0, the event queue log2 depth in bits 10:6 and the command queue log2 depth in bits 15:11 (0x41D0 by default). ID5 holds 4K granule in bit 0, 64K granule in bit 1 and the output size code in bits 4:2 (0x13 by default). ID2 to ID4 read as zero.
- R8: After reset the command queue producer and consumer indices (0x098, 0x09C) and the event queue indices (0x0A8, 0x0AC) read zero. The command queue base bits 4:0 read `CMDQ_LOG2` (8) and the event queue base bits 4:0 read `EVTQ_LOG2` (7).
- R9: The interrupt control acknowledge word at 0x054 reads the same value as the interrupt control word at 0x050.
- R10: A 4-byte read of an unmapped offset, misaligned ones included, returns zero with code 0.
- R11: The implementation identity word at 0x018 returns `IMPL_ID` (0x00001A3B by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | Request is a write |
| req_addr | input | AW | Byte address inside the window |
| req_size | input | 4 | Access size in bytes |
| rsp_vld | output | 1 | Response present |
| rsp_code | output | 2 | 0 OK, 2 error |
| rsp_data | output | 64 | Read data, little-endian |

## Verification
The hardest case to reach from the ports is a write that should leave the registers untouched. The write itself only returns an error code, so the stimulus writes to a queue index and to a queue base, then reads both back. Any leak would show up as a value other than the reset value. The alias is checked by reading the same registers through the upper page and expecting lower-page values. The width rules are checked by reading each 64-bit register as one 8-byte read and as two 4-byte halves. A non-64-bit register is also read with 8 bytes, and that read must return zero.

// File: rtl/ctlreg_rd_dec.sv
module ctlreg_rd_dec #(
  parameter int          AW        = 17,
  parameter int          CMDQ_LOG2 = 8,
  parameter int          EVTQ_LOG2 = 7,
  parameter int          SID_BITS  = 16,
  parameter int          OAS_CODE  = 4,
  parameter logic [31:0] IMPL_ID   = 32'h0000_1A3B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_size,
  output logic          rsp_vld,
  output logic [1:0]    rsp_code,
  output logic [63:0]   rsp_data
);
  localparam int OW = AW - 1;
  localparam logic [1:0] RC_OK  = 2'd0;
  localparam logic [1:0] RC_ERR = 2'd2;

  localparam logic [31:0] ID0_V = 32'h0000_0369;
  localparam logic [31:0] ID1_V = {16'h0, 5'(CMDQ_LOG2), 5'(EVTQ_LOG2), 6'(SID_BITS)};
  localparam logic [31:0] ID5_V = {27'h0, 3'(OAS_CODE), 1'b1, 1'b1};

  logic [31:0] off;
  assign off = 32'(req_addr[OW-1:0]);

  logic [63:0] ecfg0_q, tbl_base_q, cmd_base_q, evt_base_q;
  logic [31:0] cmd_prod_q, cmd_cons_q, evt_prod_q, evt_cons_q;
  logic [31:0] irq_ctl_q, err_q, err_ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecfg0_q    <= '0;
      tbl_base_q <= '0;
      cmd_base_q <= {59'h0, 5'(CMDQ_LOG2)};
      evt_base_q <= {59'h0, 5'(EVTQ_LOG2)};
      cmd_prod_q <= '0;
      cmd_cons_q <= '0;
      evt_prod_q <= '0;
      evt_cons_q <= '0;
      irq_ctl_q  <= '0;
      err_q      <= '0;
      err_ack_q  <= '0;
    end
  end

  logic [31:0] w32;
  always_comb begin
    case (off)
      32'h000: w32 = ID0_V;
      32'h004: w32 = ID1_V;
      32'h014: w32 = ID5_V;
      32'h018: w32 = IMPL_ID;
      32'h050,
      32'h054: w32 = irq_ctl_q;
      32'h060: w32 = err_q;
      32'h064: w32 = err_ack_q;
      32'h068: w32 = ecfg0_q[31:0];
      32'h06C: w32 = ecfg0_q[63:32];
      32'h080: w32 = tbl_base_q[31:0];
      32'h084: w32 = tbl_base_q[63:32];
      32'h090: w32 = cmd_base_q[31:0];
      32'h094: w32 = cmd_base_q[63:32];
      32'h098: w32 = cmd_prod_q;
      32'h09C: w32 = cmd_cons_q;
      32'h0A0: w32 = evt_base_q[31:0];
      32'h0A4: w32 = evt_base_q[63:32];
      32'h0A8: w32 = evt_prod_q;
      32'h0AC: w32 = evt_cons_q;
      default: w32 = '0;
    endcase
  end

  logic [63:0] w64;
  always_comb begin
    case (off)
      32'h068: w64 = ecfg0_q;
      32'h080: w64 = tbl_base_q;
      32'h090: w64 = cmd_base_q;
      32'h0A0: w64 = evt_base_q;
      default: w64 = '0;
    endcase
  end

  logic size_ok, is_err;
  logic [63:0] nxt_data;
  assign size_ok  = (req_size == 4'd4) || (req_size == 4'd8);
  assign is_err   = req_wr || !size_ok;
  assign nxt_data = is_err ? 64'h0 : (req_size == 4'd8) ? w64 : {32'h0, w32};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_code <= RC_OK;
      rsp_data <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_code <= is_err ? RC_ERR : RC_OK;
        rsp_data <= nxt_data;
      end
    end
  end
endmodule

module ctlreg_rd_dec_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic          req_wr,
  input logic [AW-1:0] req_addr,
  input logic [3:0]    req_size,
  input logic          rsp_vld,
  input logic [1:0]    rsp_code,
  input logic [63:0]   rsp_data
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  // R2
  write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr) |=> (rsp_code == 2'd2 && rsp_data == 64'h0));
  // R3
  bad_size_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr && req_size != 4'd4 && req_size != 4'd8) |=> (rsp_code == 2'd2 && rsp_data == 64'h0));
  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr && req_size == 4'd4) |=> (rsp_code == 2'd0 && rsp_data[63:32] == 32'h0));
  // R5
  wide_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr && req_size == 4'd8) |=> (rsp_code == 2'd0));
endmodule

bind ctlreg_rd_dec ctlreg_rd_dec_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
  .req_addr(req_addr), .req_size(req_size), .rsp_vld(rsp_vld),
  .rsp_code(rsp_code), .rsp_data(rsp_data)
);

// File: tb/sim_ctlreg_rd_dec.sv
`timescale 1ns/1ps
module sim_ctlreg_rd_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic        req_wr = 1'b0;
  logic [16:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic        rsp_vld;
  logic [1:0]  rsp_code;
  logic [63:0] rsp_data;

  always #2 clk = ~clk;

  ctlreg_rd_dec u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_size(req_size), .rsp_vld(rsp_vld),
    .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  typedef struct {
    logic [1:0]  code;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic req(input logic wr, input logic [16:0] a, input logic [3:0] sz,
                     input logic [1:0] ec, input logic [63:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    req_vld  = 1'b1;
    req_wr   = wr;
    req_addr = a;
    req_size = sz;
    e.code = ec; e.data = ed; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
    req_wr  = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R1: response with nothing pending (act vld=1 exp vld=0)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_code !== e.code || rsp_data !== e.data) begin
          n_bad++;
          $display("FAIL %s: act code=%0d data=%h exp code=%0d data=%h",
                   e.tag, rsp_code, rsp_data, e.code, e.data);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired (act hung, exp finished)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_vld !== 1'b0 || rsp_code !== 2'd0 || rsp_data !== 64'h0) begin
      n_bad++;
      $display("FAIL R1: reset state act vld=%b code=%0d data=%h exp 0 0 0", rsp_vld, rsp_code, rsp_data);
    end
    rst_n = 1'b1;

    // R7 identification words
    req(0, 17'h00000, 4'd4, 2'd0, 64'h369,  "R7 ID0");
    req(0, 17'h00004, 4'd4, 2'd0, 64'h41D0, "R7 ID1");
    req(0, 17'h00008, 4'd4, 2'd0, 64'h0,    "R7 ID2");
    req(0, 17'h00010, 4'd4, 2'd0, 64'h0,    "R7 ID4");
    req(0, 17'h00014, 4'd4, 2'd0, 64'h13,   "R7 ID5");
    // R11
    req(0, 17'h00018, 4'd4, 2'd0, 64'h1A3B, "R11 impl id");
    // R8 queue reset values
    req(0, 17'h00090, 4'd4, 2'd0, 64'h8, "R8 cmd base lo");
    req(0, 17'h000A0, 4'd4, 2'd0, 64'h7, "R8 evt base lo");
    req(0, 17'h00098, 4'd4, 2'd0, 64'h0, "R8 cmd prod");
    req(0, 17'h0009C, 4'd4, 2'd0, 64'h0, "R8 cmd cons");
    req(0, 17'h000A8, 4'd4, 2'd0, 64'h0, "R8 evt prod");
    req(0, 17'h000AC, 4'd4, 2'd0, 64'h0, "R8 evt cons");
    // R6 upper halves
    req(0, 17'h00094, 4'd4, 2'd0, 64'h0, "R6 cmd base hi");
    req(0, 17'h000A4, 4'd4, 2'd0, 64'h0, "R6 evt base hi");
    // R5 wide reads
    req(0, 17'h00090, 4'd8, 2'd0, 64'h8, "R5 cmd base 64");
    req(0, 17'h000A0, 4'd8, 2'd0, 64'h7, "R5 evt base 64");
    req(0, 17'h00068, 4'd8, 2'd0, 64'h0, "R5 err cfg0 64");
    req(0, 17'h00000, 4'd8, 2'd0, 64'h0, "R5 wide ID0 raz");
    req(0, 17'h00018, 4'd8, 2'd0, 64'h0, "R5 wide impl raz");
    // R9
    req(0, 17'h00050, 4'd4, 2'd0, 64'h0, "R9 irq ctl");
    req(0, 17'h00054, 4'd4, 2'd0, 64'h0, "R9 irq ack");
    // R10 unmapped and misaligned
    req(0, 17'h00FF0, 4'd4, 2'd0, 64'h0, "R10 unmapped");
    req(0, 17'h00001, 4'd4, 2'd0, 64'h0, "R10 misaligned");
    // R4 alias through upper page
    req(0, 17'h10000, 4'd4, 2'd0, 64'h369,  "R4 alias ID0");
    req(0, 17'h10004, 4'd4, 2'd0, 64'h41D0, "R4 alias ID1");
    req(0, 17'h10090, 4'd8, 2'd0, 64'h8,    "R4 alias cmd base");
    req(0, 17'h10018, 4'd4, 2'd0, 64'h1A3B, "R4 alias impl");
    // R3 illegal sizes
    req(0, 17'h00000, 4'd1, 2'd2, 64'h0, "R3 size1");
    req(0, 17'h00004, 4'd2, 2'd2, 64'h0, "R3 size2");
    req(0, 17'h00090, 4'd0, 2'd2, 64'h0, "R3 size0");
    // R2 writes refused and change nothing
    req(1, 17'h00098, 4'd4, 2'd2, 64'h0, "R2 write prod");
    req(1, 17'h00090, 4'd8, 2'd2, 64'h0, "R2 write cmd base");
    req(1, 17'h100A8, 4'd4, 2'd2, 64'h0, "R2 write evt prod alias");
    req(0, 17'h00098, 4'd4, 2'd0, 64'h0, "R2 prod after write");
    req(0, 17'h00090, 4'd8, 2'd0, 64'h8, "R2 cmd base after write");
    req(0, 17'h000A8, 4'd4, 2'd0, 64'h0, "R2 evt prod after write");
    idle();
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (rsp_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: idle act vld=%b exp 0", rsp_vld);
    end
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1: pending responses act %0d exp 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule